// File: doc/BRIEF.md
# MEI Snoop Response Controller

This block keeps a small write-back data cache coherent with other bus masters. Each cache line holds one of three states: Modified, Exclusive or Invalid. No Shared state exists. While another master owns the address bus, the block watches for transfer starts that are marked global. It looks up the broadcast address in a direct-mapped tag array of 16 lines and reacts in one of three ways. It may do nothing. It may drop an Exclusive line. For a Modified line, it asserts address retry so that the other master repeats its access later, and it asks for the dirty line to be written back.

When the local core owns the bus, the block drives the global indication from the coherence attribute of the page being accessed. The local core also presents its own accesses to the tag array. Read misses fill a line, writes make a line dirty, and the state of the addressed line is visible on a lookup port. The block does not hold the cache data, arbitrate for the bus, or time the data phase of the write-back.

Top module: `mei_snoop_ctl`

## Requirements
- R1: After reset, every line reads as Invalid (state code 2'b00), `bus_retry_o` is low and `co_req_o` is low.
- R2: When `own_bus_i` is high, `bus_gbl_oe_o` is high and `bus_gbl_o` equals `own_m_attr_i`. When `own_bus_i` is low, both outputs are low.
- R3: A snoop is taken only when `bus_ts_i` and `bus_gbl_i` are high in the same cycle while `own_bus_i` is low. Any other transfer start causes no retry and no change to any line.
- R4: A snoop looks up address bits [8:5] as the line index and bits [31:9] as the tag. On a miss it produces no retry and no change to any line.
- R5: A snoop hit on an Exclusive line (code 2'b01) with coherent attributes makes the line Invalid, with no retry.
- R6: A snoop hit on a Modified line (code 2'b10) with coherent attributes raises `bus_retry_o` in the cycle after the transfer start, and only in that cycle. If no castout is pending, `co_req_o` rises one cycle later and `co_addr_o` carries the line address with bits [4:0] zero. The line stays Modified until the cycle in which `co_req_o` and `co_ack_i` are both high, and from the next cycle on the line is Invalid and `co_req_o` is low.
- R7: Snoop hits on lines filled with attributes other than WIM = 3'b001 cause no retry and no state change.
- R8: While a castout is pending, every snoop hit on a Modified line is retried, including the line being written back. A hit on a different Modified line starts no second castout and leaves `co_addr_o` unchanged.
- R9: A local read miss fills the line as Exclusive. A local write to an Exclusive line makes it Modified. A local write miss fills the line as Modified. A read hit changes nothing. The line's coherence attribute is stored from `core_wim_i` on a fill.
- R10: A local access is dropped when its index equals the index of a pending castout, or the index of a snoop being looked up in that cycle.
- R11: `core_state_o` shows, in the same cycle, the state of the line that `core_addr_i` selects when the tags match, and Invalid otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_bus_i | input | 1 | Local core is address-bus master |
| own_m_attr_i | input | 1 | Coherence attribute of the local access |
| bus_gbl_o | output | 1 | Global indication driven when master |
| bus_gbl_oe_o | output | 1 | Output enable for the global indication |
| bus_ts_i | input | 1 | Transfer start from another master |
| bus_gbl_i | input | 1 | Global indication from another master |
| bus_addr_i | input | 32 | Snooped address |
| bus_retry_o | output | 1 | Address retry request |
| co_req_o | output | 1 | Castout request for a dirty line |
| co_addr_o | output | 32 | Line address of the castout |
| co_ack_i | input | 1 | Castout accepted |
| core_req_i | input | 1 | Local access valid |
| core_we_i | input | 1 | Local access is a write |
| core_addr_i | input | 32 | Local access address, also the state lookup address |
| core_wim_i | input | 3 | Page attributes of the local access |
| core_state_o | output | 2 | State of the addressed line |

## Verification
The state lookup is combinational, so `core_state_o` is due in the same cycle that `core_addr_i` is driven. Retry is due exactly one cycle after the qualified transfer start. A castout request is due two cycles after it. A state change from a snoop or an acknowledge shows two cycles after the snoop, or one cycle after the acknowledge. The driver tasks apply inputs just after a rising edge and push each expected value tagged with the cycle number in which it is due. The monitor compares only at falling edges and only entries whose cycle number matches, so every check lands in the cycle that the latency count above predicts. Items left in the queue at the end count as failures.

// File: rtl/mei_snoop_ctl.sv
module mei_snoop_ctl #(
  parameter int AW    = 32,
  parameter int OFS_W = 5,
  parameter int IDX_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          own_bus_i,
  input  logic          own_m_attr_i,
  output logic          bus_gbl_o,
  output logic          bus_gbl_oe_o,
  input  logic          bus_ts_i,
  input  logic          bus_gbl_i,
  input  logic [AW-1:0] bus_addr_i,
  output logic          bus_retry_o,
  output logic          co_req_o,
  output logic [AW-1:0] co_addr_o,
  input  logic          co_ack_i,
  input  logic          core_req_i,
  input  logic          core_we_i,
  input  logic [AW-1:0] core_addr_i,
  input  logic [2:0]    core_wim_i,
  output logic [1:0]    core_state_o
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = AW - OFS_W - IDX_W;
  localparam logic [1:0] ST_I = 2'b00, ST_E = 2'b01, ST_M = 2'b10;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [1:0]       st_q  [LINES];
  logic             coh_q [LINES];

  logic             snp_v_q;
  logic [AW-1:0]    snp_addr_q;
  logic             co_pend_q;
  logic [IDX_W-1:0] co_idx_q;
  logic [AW-1:0]    co_addr_q;

  assign bus_gbl_oe_o = own_bus_i;
  assign bus_gbl_o    = own_bus_i & own_m_attr_i;

  wire              qual     = bus_ts_i & bus_gbl_i & ~own_bus_i;
  wire [IDX_W-1:0]  snp_idx  = snp_addr_q[OFS_W +: IDX_W];
  wire [TAG_W-1:0]  snp_tag  = snp_addr_q[AW-1 -: TAG_W];
  wire              snp_hit  = snp_v_q && st_q[snp_idx] != ST_I &&
                               tag_q[snp_idx] == snp_tag && coh_q[snp_idx];
  wire              snp_mod  = snp_hit && st_q[snp_idx] == ST_M;
  wire              snp_exc  = snp_hit && st_q[snp_idx] == ST_E;
  wire              launch   = snp_mod && !co_pend_q;
  wire              co_done  = co_pend_q && co_ack_i;

  wire [IDX_W-1:0]  core_idx = core_addr_i[OFS_W +: IDX_W];
  wire [TAG_W-1:0]  core_tag = core_addr_i[AW-1 -: TAG_W];
  wire              core_hit = st_q[core_idx] != ST_I && tag_q[core_idx] == core_tag;
  wire              core_blk = (co_pend_q && co_idx_q == core_idx) ||
                               (snp_v_q && snp_idx == core_idx);
  wire              core_go  = core_req_i && !core_blk;
  wire              core_fill = core_go && !core_hit && (core_we_i || 1'b1);

  assign bus_retry_o  = snp_mod;
  assign co_req_o     = co_pend_q;
  assign co_addr_o    = co_addr_q;
  assign core_state_o = core_hit ? st_q[core_idx] : ST_I;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_v_q    <= 1'b0;
      snp_addr_q <= '0;
    end else begin
      snp_v_q    <= qual;
      snp_addr_q <= bus_addr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      co_pend_q <= 1'b0;
      co_idx_q  <= '0;
      co_addr_q <= '0;
    end else if (launch) begin
      co_pend_q <= 1'b1;
      co_idx_q  <= snp_idx;
      co_addr_q <= {snp_tag, snp_idx, {OFS_W{1'b0}}};
    end else if (co_done) begin
      co_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (core_fill) tag_q[core_idx] <= core_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        coh_q[i] <= 1'b0;
      end
    end else begin
      if (core_go) begin
        if (!core_hit) begin
          st_q[core_idx]  <= core_we_i ? ST_M : ST_E;
          coh_q[core_idx] <= (core_wim_i == 3'b001);
        end else if (core_we_i) begin
          st_q[core_idx] <= ST_M;
        end
      end
      if (snp_exc) st_q[snp_idx] <= ST_I;
      if (co_done) st_q[co_idx_q] <= ST_I;
    end
  end
endmodule

module mei_snoop_ctl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          own_bus_i,
  input logic          own_m_attr_i,
  input logic          bus_gbl_o,
  input logic          bus_gbl_oe_o,
  input logic          bus_ts_i,
  input logic          bus_gbl_i,
  input logic          bus_retry_o,
  input logic          co_req_o,
  input logic [AW-1:0] co_addr_o,
  input logic          co_ack_i
);
  a_r2_gbl_released: assert property (@(posedge clk) disable iff (!rst_n)
    !own_bus_i |-> !bus_gbl_oe_o && !bus_gbl_o);

  a_r3_retry_needs_qualified_start: assert property (@(posedge clk) disable iff (!rst_n)
    bus_retry_o |-> $past(bus_ts_i && bus_gbl_i && !own_bus_i));

  a_r6_castout_follows_retry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(co_req_o) |-> $past(bus_retry_o));

  a_r6_castout_held: assert property (@(posedge clk) disable iff (!rst_n)
    co_req_o && !co_ack_i |=> co_req_o && $stable(co_addr_o));

  a_r6_ack_drops_request: assert property (@(posedge clk) disable iff (!rst_n)
    co_req_o && co_ack_i |=> !co_req_o);

  a_r6_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    co_req_o |-> co_addr_o[4:0] == 5'b0);
endmodule

bind mei_snoop_ctl mei_snoop_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .own_bus_i(own_bus_i), .own_m_attr_i(own_m_attr_i),
  .bus_gbl_o(bus_gbl_o), .bus_gbl_oe_o(bus_gbl_oe_o), .bus_ts_i(bus_ts_i),
  .bus_gbl_i(bus_gbl_i), .bus_retry_o(bus_retry_o), .co_req_o(co_req_o),
  .co_addr_o(co_addr_o), .co_ack_i(co_ack_i)
);

// File: tb/mei_snoop_ctl_bench.sv
module mei_snoop_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic own_bus_i = 1'b0, own_m_attr_i = 1'b0;
  logic bus_gbl_o, bus_gbl_oe_o;
  logic bus_ts_i = 1'b0, bus_gbl_i = 1'b0;
  logic [31:0] bus_addr_i = '0;
  logic bus_retry_o, co_req_o;
  logic [31:0] co_addr_o;
  logic co_ack_i = 1'b0;
  logic core_req_i = 1'b0, core_we_i = 1'b0;
  logic [31:0] core_addr_i = '0;
  logic [2:0] core_wim_i = 3'b001;
  logic [1:0] core_state_o;

  always #2 clk = ~clk;

  mei_snoop_ctl u_mei_snoop_ctl (
    .clk(clk), .rst_n(rst_n), .own_bus_i(own_bus_i), .own_m_attr_i(own_m_attr_i),
    .bus_gbl_o(bus_gbl_o), .bus_gbl_oe_o(bus_gbl_oe_o), .bus_ts_i(bus_ts_i),
    .bus_gbl_i(bus_gbl_i), .bus_addr_i(bus_addr_i), .bus_retry_o(bus_retry_o),
    .co_req_o(co_req_o), .co_addr_o(co_addr_o), .co_ack_i(co_ack_i),
    .core_req_i(core_req_i), .core_we_i(core_we_i), .core_addr_i(core_addr_i),
    .core_wim_i(core_wim_i), .core_state_o(core_state_o)
  );

  localparam int K_RETRY = 0, K_COREQ = 1, K_COADDR = 2, K_STATE = 3;
  int checks = 0, fails = 0, cyc = 0;
  int q_cyc[$];
  int q_kind[$];
  logic [31:0] q_exp[$];
  string q_req[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] la(int tag, int idx);
    return (32'(tag) << 9) | (32'(idx) << 5);
  endfunction

  task automatic push(int c, int k, logic [31:0] e, string r);
    q_cyc.push_back(c); q_kind.push_back(k); q_exp.push_back(e); q_req.push_back(r);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    bus_ts_i = 1'b0; bus_gbl_i = 1'b0; core_req_i = 1'b0; core_we_i = 1'b0;
    co_ack_i = 1'b0; own_bus_i = 1'b0; own_m_attr_i = 1'b0;
  endtask

  task automatic snoop(logic [31:0] a, logic g, logic own, logic exp_retry, string r);
    bus_ts_i = 1'b1; bus_gbl_i = g; own_bus_i = own; bus_addr_i = a;
    push(cyc + 1, K_RETRY, {31'b0, exp_retry}, r);
    tick();
  endtask

  task automatic core(logic [31:0] a, logic we, logic [2:0] wim);
    core_req_i = 1'b1; core_we_i = we; core_addr_i = a; core_wim_i = wim;
    tick();
  endtask

  task automatic probe(logic [31:0] a, logic [1:0] e, string r);
    core_addr_i = a;
    push(cyc, K_STATE, {30'b0, e}, r);
    tick();
  endtask

  task automatic expect_co(logic req, logic [31:0] a, string r);
    push(cyc, K_COREQ, {31'b0, req}, r);
    if (req) push(cyc, K_COADDR, a, r);
  endtask

  task automatic ack();
    co_ack_i = 1'b1;
    push(cyc + 1, K_COREQ, 32'd0, "R6");
    tick();
  endtask

  task automatic direct(logic [31:0] act, logic [31:0] e, string r);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, e);
    end
  endtask

  always @(negedge clk) begin
    for (int i = q_cyc.size() - 1; i >= 0; i--) begin
      if (q_cyc[i] <= cyc) begin
        logic [31:0] act;
        case (q_kind[i])
          K_RETRY:  act = {31'b0, bus_retry_o};
          K_COREQ:  act = {31'b0, co_req_o};
          K_COADDR: act = co_addr_o;
          default:  act = {30'b0, core_state_o};
        endcase
        if (q_cyc[i] < cyc) act = 32'hdead_beef;
        direct(act, q_exp[i], q_req[i]);
        q_cyc.delete(i); q_kind.delete(i); q_exp.delete(i); q_req.delete(i);
      end
    end
  end

  task automatic finish_run();
    checks += q_cyc.size();
    fails  += q_cyc.size();
    if (q_cyc.size() != 0) $display("FAIL queue: actual %0d items left expected 0", q_cyc.size());
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    direct({31'b0, bus_retry_o}, 32'd0, "R1 retry");
    direct({31'b0, co_req_o}, 32'd0, "R1 coreq");
    tick();
    probe(la(0, 0), 2'b00, "R1 line0");
    probe(la(7, 15), 2'b00, "R1 line15");

    own_bus_i = 1'b1; own_m_attr_i = 1'b1; @(negedge clk);
    direct({30'b0, bus_gbl_oe_o, bus_gbl_o}, 32'd3, "R2 master global");
    tick();
    own_bus_i = 1'b1; own_m_attr_i = 1'b0; @(negedge clk);
    direct({30'b0, bus_gbl_oe_o, bus_gbl_o}, 32'd2, "R2 master local");
    tick();
    own_m_attr_i = 1'b1; @(negedge clk);
    direct({30'b0, bus_gbl_oe_o, bus_gbl_o}, 32'd0, "R2 released");
    tick();

    core(la(1, 1), 1'b0, 3'b001);
    probe(la(1, 1), 2'b01, "R9 read miss fills E");
    probe(la(1, 1) + 32'd12, 2'b01, "R11 offset ignored");
    probe(la(2, 1), 2'b00, "R11 tag mismatch");

    snoop(la(1, 1), 1'b0, 1'b0, 1'b0, "R3 not global");
    tick();
    probe(la(1, 1), 2'b01, "R3 not global keeps E");
    snoop(la(1, 1), 1'b1, 1'b1, 1'b0, "R3 own bus");
    tick();
    probe(la(1, 1), 2'b01, "R3 own bus keeps E");

    snoop(la(2, 1), 1'b1, 1'b0, 1'b0, "R4 miss");
    tick();
    probe(la(1, 1), 2'b01, "R4 miss keeps E");

    snoop(la(1, 1) + 32'd4, 1'b1, 1'b0, 1'b0, "R5 E hit");
    tick();
    probe(la(1, 1), 2'b00, "R5 E hit invalidates");

    core(la(3, 2), 1'b0, 3'b001);
    core(la(3, 2), 1'b1, 3'b001);
    probe(la(3, 2), 2'b10, "R9 write makes M");
    core(la(4, 3), 1'b1, 3'b001);
    probe(la(4, 3), 2'b10, "R9 write miss fills M");
    core(la(4, 3), 1'b0, 3'b001);
    probe(la(4, 3), 2'b10, "R9 read hit keeps M");

    snoop(la(3, 2), 1'b1, 1'b0, 1'b1, "R6 M hit retry");
    push(cyc + 1, K_RETRY, 32'd0, "R6 retry one cycle");
    tick();
    expect_co(1'b1, la(3, 2), "R6 castout");
    probe(la(3, 2), 2'b10, "R6 still M while pending");

    snoop(la(3, 2), 1'b1, 1'b0, 1'b1, "R8 same line retried");
    tick();
    snoop(la(4, 3), 1'b1, 1'b0, 1'b1, "R8 other M retried");
    tick();
    expect_co(1'b1, la(3, 2), "R8 no second castout");
    core(la(5, 2), 1'b0, 3'b001);
    probe(la(3, 2), 2'b10, "R10 access to pending line dropped");

    ack();
    probe(la(3, 2), 2'b00, "R6 ack invalidates");
    probe(la(4, 3), 2'b10, "R8 other line kept M");

    snoop(la(4, 3), 1'b1, 1'b0, 1'b1, "R6 second line retry");
    tick();
    expect_co(1'b1, la(4, 3), "R6 second castout");
    tick();
    ack();
    probe(la(4, 3), 2'b00, "R6 second ack");

    core(la(6, 5), 1'b0, 3'b101);
    core(la(6, 5), 1'b1, 3'b101);
    snoop(la(6, 5), 1'b1, 1'b0, 1'b0, "R7 non-coherent M");
    tick();
    probe(la(6, 5), 2'b10, "R7 M kept");
    core(la(7, 6), 1'b0, 3'b000);
    snoop(la(7, 6), 1'b1, 1'b0, 1'b0, "R7 non-coherent E");
    tick();
    probe(la(7, 6), 2'b01, "R7 E kept");

    core(la(8, 9), 1'b0, 3'b001);
    bus_ts_i = 1'b1; bus_gbl_i = 1'b1; bus_addr_i = la(1, 9);
    tick();
    core(la(8, 9), 1'b1, 3'b001);
    probe(la(8, 9), 2'b01, "R10 access during snoop lookup dropped");

    tick();
    finish_run();
  end
endmodule